// File: doc/BRIEF.md
# Halfword Integer Execute Unit

This block decodes and retires a small group of register and immediate integer operations for a 32-bit core with a bank of 32 general registers. Each operation is presented as a first halfword carrying two register or immediate fields and a six-bit operation code. A second halfword holding a 16-bit immediate is presented alongside it and is used only by the operations that take one. The block holds the register bank and the condition flags (carry, overflow, sign, zero). It writes the destination register and updates the flags in the cycle in which the operation is accepted.

The supported operations are register copy, small-immediate load, add-immediate copy, upper-half add copy, three forms of signed 16-bit multiply, bitwise complement, OR and OR with an immediate. An all-zero halfword does nothing. Any other operation code is reported on a one-cycle illegal-operation output and changes no state. A debug read port lets the surrounding logic observe any register. The block accepts one operation per cycle through a valid/ready pair.

Top module: `hwx_exec_unit`

## Requirements
- R1: A synchronous active-low reset clears all registers, all four flags and the illegal output. `in_ready` reads 1 once reset is released.
- R2: First halfword fields: destination register in bits 15:11, operation code in bits 10:5, source register or 5-bit immediate in bits 4:0. The second halfword is the 16-bit immediate. Register 0 always reads as zero, and writes to it are dropped.
- R3: Code 000000 copies the source register into the destination. Code 010000 writes the 5-bit immediate, sign-extended to 32 bits.
- R4: Code 110001 writes source + sign-extended imm16. Code 110010 writes source + (imm16 shifted left by 16).
- R5: Code 000111 writes the signed product of the low 16 bits of destination and source. Code 010111 writes the low 16 bits of the destination times the sign-extended 5-bit immediate. Code 110111 writes the low 16 bits of the source times imm16, signed. Each writes a full 32-bit product.
- R6: Code 000001 writes the complement of the source. Code 001000 writes destination OR source. Code 110100 writes source OR zero-extended imm16.
- R7: The three bitwise operations clear OV, set S to bit 31 of the result and set Z when the result is zero. They do so even when the destination is register 0. No operation ever changes CY.
- R8: Copy, immediate and multiply operations leave all four flags unchanged.
- R9: Halfword 0x0000 changes no register and no flag.
- R10: Any code not listed in R3 to R6 drives `illegal` high for exactly the cycle after acceptance and changes no register and no flag.
- R11: An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. Operations can be accepted on consecutive cycles. Results are visible on the debug port and the flags from the cycle after acceptance. Cycles with `in_valid` low change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Block can accept an operation |
| in_hw0 | input | 16 | First halfword (fields and code) |
| in_hw1 | input | 16 | Immediate halfword |
| peek_addr | input | 5 | Debug read register index |
| peek_data | output | 32 | Debug read value |
| flag_cy | output | 1 | Carry flag |
| flag_ov | output | 1 | Overflow flag |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| illegal | output | 1 | Undefined operation code accepted last cycle |

## Verification
Every cycle, the assertions check the flag rules: CY never moves, bitwise operations clear OV and set Z from their result, and other operations and idle cycles hold the flags. They also check that the illegal pulse follows an undefined code and leaves the flags alone, that a register write lands, and that register 0 reads zero. Only the bench's sweeps can show the arithmetic itself. The bench runs every one of the 64 codes over a matrix of source and destination registers with edge-case contents. This covers sign versus zero extension, multiplies that use only the low halves, writes dropped at register 0, and the absence of any register change on undefined codes.

// File: rtl/hwx_pkg.sv
// Package: shared operation kinds and operation codes for the halfword
// execute unit. Assumes the six-bit code field of the first halfword.
package hwx_pkg;
    localparam logic [5:0] OP_MOVR   = 6'b000000;
    localparam logic [5:0] OP_MOVI5  = 6'b010000;
    localparam logic [5:0] OP_ADDI   = 6'b110001;
    localparam logic [5:0] OP_ADDHI  = 6'b110010;
    localparam logic [5:0] OP_MULR   = 6'b000111;
    localparam logic [5:0] OP_MULI5  = 6'b010111;
    localparam logic [5:0] OP_MULI16 = 6'b110111;
    localparam logic [5:0] OP_NOT    = 6'b000001;
    localparam logic [5:0] OP_OR     = 6'b001000;
    localparam logic [5:0] OP_ORI    = 6'b110100;

    typedef enum logic [3:0] {
        K_MOVR, K_MOVI5, K_ADDI, K_ADDHI,
        K_MULR, K_MULI5, K_MULI16,
        K_NOT, K_OR, K_ORI, K_BAD
    } kind_e;
endpackage

// File: rtl/hwx_decode.sv
// Decoder: splits the first halfword into its fields and maps the code to
// an operation kind. Purely combinational; unknown codes map to K_BAD.
module hwx_decode
    import hwx_pkg::*;
(
    input  logic [15:0] hw0,
    output kind_e       kind,
    output logic [4:0]  dst,
    output logic [4:0]  src
);
    assign dst = hw0[15:11];
    assign src = hw0[4:0];

    // map the six-bit code to an operation kind
    always_comb begin
        unique case (hw0[10:5])
            OP_MOVR:   kind = K_MOVR;
            OP_MOVI5:  kind = K_MOVI5;
            OP_ADDI:   kind = K_ADDI;
            OP_ADDHI:  kind = K_ADDHI;
            OP_MULR:   kind = K_MULR;
            OP_MULI5:  kind = K_MULI5;
            OP_MULI16: kind = K_MULI16;
            OP_NOT:    kind = K_NOT;
            OP_OR:     kind = K_OR;
            OP_ORI:    kind = K_ORI;
            default:   kind = K_BAD;
        endcase
    end
endmodule

// File: rtl/hwx_alu.sv
// Datapath: computes the result of one operation from the source value,
// the old destination value and the immediates. It also says whether the
// result is written and whether the flags follow it. Assumes XLEN >= 32.
module hwx_alu
    import hwx_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  kind_e            kind,
    input  logic [XLEN-1:0]  src_val,
    input  logic [XLEN-1:0]  dst_val,
    input  logic [4:0]       imm5,
    input  logic [15:0]      imm16,
    output logic [XLEN-1:0]  result,
    output logic             wr_en,
    output logic             flag_upd
);
    localparam int HW = 16;

    logic [XLEN-1:0] sx5, sx16, zx16, hi16, prod;
    logic [HW-1:0]   mul_a, mul_b;

    assign sx5  = {{(XLEN-5){imm5[4]}}, imm5};
    assign sx16 = {{(XLEN-HW){imm16[HW-1]}}, imm16};
    assign zx16 = {{(XLEN-HW){1'b0}}, imm16};
    assign hi16 = zx16 << HW;

    // choose the two low-half multiply operands per multiply form
    always_comb begin
        mul_a = dst_val[HW-1:0];
        mul_b = src_val[HW-1:0];
        if (kind == K_MULI5) begin
            mul_b = sx5[HW-1:0];
        end else if (kind == K_MULI16) begin
            mul_a = src_val[HW-1:0];
            mul_b = imm16;
        end
    end

    // signed product of the two halves, sign-extended to full width first
    assign prod = $signed({{(XLEN-HW){mul_a[HW-1]}}, mul_a})
                * $signed({{(XLEN-HW){mul_b[HW-1]}}, mul_b});

    // select the result and its side effects by operation kind
    always_comb begin
        result   = '0;
        wr_en    = 1'b1;
        flag_upd = 1'b0;
        unique case (kind)
            K_MOVR:   result = src_val;
            K_MOVI5:  result = sx5;
            K_ADDI:   result = src_val + sx16;
            K_ADDHI:  result = src_val + hi16;
            K_MULR, K_MULI5, K_MULI16: result = prod;
            K_NOT:    begin result = ~src_val;         flag_upd = 1'b1; end
            K_OR:     begin result = dst_val | src_val; flag_upd = 1'b1; end
            K_ORI:    begin result = src_val | zx16;    flag_upd = 1'b1; end
            default:  wr_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/hwx_regfile.sv
// Register bank: NREG words of XLEN bits, NRD combinational read ports, one
// synchronous write port. Entry 0 is never written and reads as zero.
module hwx_regfile #(
    parameter int NREG = 32,
    parameter int XLEN = 32,
    parameter int NRD  = 3,
    localparam int AW  = $clog2(NREG)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [AW-1:0]             waddr,
    input  logic [XLEN-1:0]           wdata,
    input  logic [NRD-1:0][AW-1:0]    raddr,
    output logic [NRD-1:0][XLEN-1:0]  rdata
);
    logic [XLEN-1:0] mem [NREG];

    // clear on reset, otherwise store into any entry except zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (we && waddr != '0) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        // read port g, forced to zero for entry zero
        assign rdata[g] = (raddr[g] == '0) ? '0 : mem[raddr[g]];
    end

    a_r11_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr != '0) |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/hwx_exec_unit.sv
// Top: accepts one halfword operation per cycle, reads its operands from
// the register bank, writes the result and updates the flags on the same
// edge. Assumes the immediate halfword is valid together with the first.
module hwx_exec_unit
    import hwx_pkg::*;
#(
    parameter int NREG = 32,
    parameter int XLEN = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [15:0]     in_hw0,
    input  logic [15:0]     in_hw1,
    input  logic [AW-1:0]   peek_addr,
    output logic [XLEN-1:0] peek_data,
    output logic            flag_cy,
    output logic            flag_ov,
    output logic            flag_s,
    output logic            flag_z,
    output logic            illegal
);
    kind_e                   kind;
    logic [4:0]              dst, src;
    logic [XLEN-1:0]         result;
    logic                    wr_en, flag_upd, accept;
    logic [2:0][AW-1:0]      raddr;
    logic [2:0][XLEN-1:0]    rdata;

    hwx_decode u_dec (.hw0(in_hw0), .kind(kind), .dst(dst), .src(src));

    assign raddr = {peek_addr, AW'(dst), AW'(src)};

    hwx_regfile #(.NREG(NREG), .XLEN(XLEN), .NRD(3)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .we(accept && wr_en), .waddr(AW'(dst)), .wdata(result),
        .raddr(raddr), .rdata(rdata)
    );

    hwx_alu #(.XLEN(XLEN)) u_alu (
        .kind(kind), .src_val(rdata[0]), .dst_val(rdata[1]),
        .imm5(src), .imm16(in_hw1),
        .result(result), .wr_en(wr_en), .flag_upd(flag_upd)
    );

    assign accept    = in_valid && in_ready;
    assign peek_data = rdata[2];

    // ready rises once reset is released
    always_ff @(posedge clk) begin
        if (!rst_n) in_ready <= 1'b0;
        else        in_ready <= 1'b1;
    end

    // flag register: bitwise results drive OV/S/Z, carry is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_cy <= 1'b0; flag_ov <= 1'b0; flag_s <= 1'b0; flag_z <= 1'b0;
        end else if (accept && flag_upd) begin
            flag_ov <= 1'b0;
            flag_s  <= result[XLEN-1];
            flag_z  <= (result == '0);
        end
    end

    // one-cycle pulse after an undefined code is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) illegal <= 1'b0;
        else        illegal <= accept && (kind == K_BAD);
    end

    a_r7_cy_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(flag_cy));
    a_r7_ov_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && flag_upd) |=> !flag_ov);
    a_r7_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && flag_upd) |=> flag_z == ($past(result) == '0));
    a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !flag_upd) |=> $stable({flag_ov, flag_s, flag_z}));
    a_r10_illegal_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind == K_BAD) |=> illegal);
    a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> $stable({flag_ov, flag_s, flag_z}));
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable({flag_ov, flag_s, flag_z}) && !illegal);
    a_r2_zero_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (peek_addr == '0) |-> peek_data == '0);
endmodule

// File: tb/hwx_exec_unit_tb_top.sv
`timescale 1ns/1ps
// Bench: shadow register model computed from the requirements, swept over
// all 64 codes and a matrix of registers with edge-case contents.
module hwx_exec_unit_tb_top;
    logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
    logic [15:0] in_hw0 = '0, in_hw1 = '0;
    logic [4:0] peek_addr = '0;
    logic [31:0] peek_data;
    logic in_ready, flag_cy, flag_ov, flag_s, flag_z, illegal;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [31:0] sh [32];
    logic m_ov = 0, m_s = 0, m_z = 0;

    always #2 clk = ~clk;

    hwx_exec_unit dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic logic [31:0] smul(input logic [15:0] a, input logic [15:0] b);
        logic signed [15:0] sa, sb;
        logic signed [31:0] p;
        sa = a; sb = b;
        p = sa * sb;
        return p;
    endfunction

    // issue one operation, update the model, check destination and flags
    task automatic exec(input logic [15:0] h0, input logic [15:0] h1);
        logic [4:0] d, s;
        logic [5:0] op;
        logic [31:0] a, b, res, x5, x16;
        bit wr, fl, bad;
        string req;
        d = h0[15:11]; s = h0[4:0]; op = h0[10:5];
        a = sh[s]; b = sh[d];
        x5 = {{27{s[4]}}, s}; x16 = {{16{h1[15]}}, h1};
        wr = 1; fl = 0; bad = 0; res = 0;
        case (op)
            6'b000000: begin res = a; req = "R3"; end
            6'b010000: begin res = x5; req = "R3"; end
            6'b110001: begin res = a + x16; req = "R4"; end
            6'b110010: begin res = a + {h1, 16'h0}; req = "R4"; end
            6'b000111: begin res = smul(b[15:0], a[15:0]); req = "R5"; end
            6'b010111: begin res = smul(b[15:0], x5[15:0]); req = "R5"; end
            6'b110111: begin res = smul(a[15:0], h1); req = "R5"; end
            6'b000001: begin res = ~a; fl = 1; req = "R6"; end
            6'b001000: begin res = b | a; fl = 1; req = "R6"; end
            6'b110100: begin res = a | {16'h0, h1}; fl = 1; req = "R6"; end
            default:   begin wr = 0; bad = 1; req = "R10"; end
        endcase
        if (h0 == 16'h0000) req = "R9";
        @(negedge clk);
        in_valid = 1; in_hw0 = h0; in_hw1 = h1;
        @(negedge clk);
        in_valid = 0;
        if (wr && d != 0) sh[d] = res;
        if (fl) begin m_ov = 0; m_s = res[31]; m_z = (res == 0); end
        peek_addr = d;
        #1;
        chk(req, peek_data, sh[d]);
        if (d == 0) chk("R2 r0 stays zero", peek_data, 32'h0);
        chk(fl ? "R7 flags" : "R8 flags", {flag_cy, flag_ov, flag_s, flag_z}, {1'b0, m_ov, m_s, m_z});
        chk("R10 illegal pulse", {31'h0, illegal}, {31'h0, bad});
    endtask

    // load a full word using the upper-half add followed by add-immediate
    task automatic load(input logic [4:0] r, input logic [31:0] v);
        logic [15:0] hi;
        hi = v[31:16] + {15'h0, v[15]};
        exec({r, 6'b110010, 5'd0}, hi);
        exec({r, 6'b110001, r}, v[15:0]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [4:0]  rl [8];
        logic [31:0] vals [8];
        rl   = '{5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd17, 5'd31};
        vals = '{32'h0, 32'h0000_0001, 32'h8000_0000, 32'hFFFF_FFFF,
                 32'h0000_7FFF, 32'h1234_8001, 32'hFFFF_8000, 32'h7FFF_FFFF};
        for (int i = 0; i < 32; i++) sh[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 32; i++) begin
            peek_addr = 5'(i); #1;
            chk("R1 reset register", peek_data, 32'h0);
        end
        chk("R1 reset flags/illegal/ready", {flag_cy, flag_ov, flag_s, flag_z, illegal, in_ready}, 6'b000001);

        // R11: back-to-back acceptance of imm5 loads
        @(negedge clk);
        for (int k = 1; k <= 8; k++) begin
            in_valid = 1;
            in_hw0 = {5'(k), 6'b010000, 5'(k * 3 + 20)};
            @(negedge clk);
            sh[k] = {{27{in_hw0[4]}}, in_hw0[4:0]};
        end
        in_valid = 0;
        for (int k = 1; k <= 8; k++) begin
            peek_addr = 5'(k); #1;
            chk("R11 back-to-back", peek_data, sh[k]);
        end

        // R11: idle cycles with a live-looking halfword change nothing
        in_hw0 = {5'd3, 6'b000001, 5'd0};
        repeat (5) @(negedge clk);
        peek_addr = 5'd3; #1;
        chk("R11 idle no write", peek_data, sh[3]);
        chk("R11 idle flags", {flag_ov, flag_s, flag_z, illegal}, {m_ov, m_s, m_z, 1'b0});

        // main sweep over all codes and a register matrix
        for (int op = 0; op < 64; op++) begin
            for (int k = 1; k < 8; k++) load(rl[k], vals[k]);
            for (int si = 0; si < 8; si++) begin
                for (int di = 0; di < 8; di++) begin
                    exec({rl[di], 6'(op), rl[si]},
                         16'h8000 ^ 16'(op * 16'h0913 + si * 16'h1111 + di * 16'h0707));
                end
            end
        end

        // R9: NOP leaves every register untouched
        exec(16'h0000, 16'hFFFF);
        for (int i = 0; i < 32; i++) begin
            peek_addr = 5'(i); #1;
            chk("R9 nop registers", peek_data, sh[i]);
        end
        finish_run();
    end
endmodule